// File: doc/BRIEF.md
# Accumulator Saturation and Rounding Datapath

This block is the arithmetic back end of a multiply-accumulate engine with two 40-bit accumulators. Each cycle it can take a 16x16 operand pair, widen both operands to 17 bits (by sign or by zero), form the product, optionally double it for fractional arithmetic, sign-extend it to 40 bits and add it to or subtract it from the selected accumulator. It can also add or subtract the other accumulator, or negate the selected one, through the same saturation path.

Each accumulator has its own saturation enable. A shared mode bit picks between clamping at the full 40-bit range and clamping at the 32-bit (1.31) range. With saturation off, a full-range overflow wraps and can raise a trap pulse. Per-accumulator guard-overflow flags and sticky saturation flags are kept, together with their OR across the two accumulators. A separate store port produces a 16-bit word rounded from bits 39:16 of either accumulator, with conventional or convergent rounding and optional clamping to the 16-bit signed range.

Top module: `mac_satround`

## Requirements
- R1: With `op_valid`=1 and `op_kind`=0, in integer signed mode, the selected accumulator (`acc_sel` 0 = A, 1 = B) becomes its old value plus the sign-extended product of `mul_a` and `mul_b` as 16-bit two's complement numbers, visible one clock later.
- R2: With `cfg_unsigned`=1 the operands are zero-extended instead of sign-extended; with `cfg_frac`=1 the product is shifted left by one bit before it is added.
- R3: `op_kind`=1 subtracts the product; `op_kind`=2 adds the other accumulator; `op_kind`=3 subtracts the other accumulator; `op_kind`=4 replaces the selected accumulator by its negation. All use the same saturation rules.
- R4: When the target's saturation enable is 1 and `cfg_sat39`=1, a result outside the signed 40-bit range is replaced by 0x7FFFFFFFFF (positive) or 0x8000000000 (negative) and the target's sticky saturation flag is set.
- R5: When the target's saturation enable is 1 and `cfg_sat39`=0, a result outside the signed 32-bit range is replaced by 0x007FFFFFFF or 0xFF80000000, the sticky saturation flag is set, and the guard-overflow flag of that accumulator stays 0.
- R6: When the target's saturation enable is 0, a result outside the signed 40-bit range keeps its low 40 bits, sets the sticky saturation flag, and `trap_req` is 1 for one cycle if `cfg_trap_en` was 1.
- R7: After each operation on an accumulator its guard-overflow flag is 1 exactly when the stored value lies outside the signed 32-bit range; `ov_any` and `sat_any` are the OR of the two per-accumulator flags.
- R8: A sticky saturation flag stays 1 until its clear input (`clr_sat_a`/`clr_sat_b`) is 1; a new saturation event in the same cycle as the clear leaves it set.
- R9: With `cfg_conv_rnd`=0, the stored word is bits 31:16 of (bits 39:16 of the accumulator plus bit 15).
- R10: With `cfg_conv_rnd`=1, rounding is the same except that when bits 15:0 equal 0x8000 the increment is bit 16 instead of bit 15.
- R11: With `cfg_wsat`=1, a rounded 24-bit value above 0x007FFF (sign from bit 39) gives 0x7FFF and one below 0xFF8000 gives 0x8000.
- R12: `st_valid` is 1 one cycle after `st_req`, and `st_word` is taken from the accumulator value before any operation issued in the same cycle as the request.
- R13: Synchronous reset clears both accumulators, all flags, `trap_req` and `st_valid`; with `op_valid`=0 or `op_kind` 5 to 7 neither accumulator nor its flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_kind | input | 3 | 0 MAC add, 1 MAC subtract, 2 add other, 3 subtract other, 4 negate |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| mul_a | input | 16 | First multiplier operand |
| mul_b | input | 16 | Second multiplier operand |
| cfg_frac | input | 1 | Fractional mode (product doubled) |
| cfg_unsigned | input | 1 | Zero-extend operands |
| cfg_conv_rnd | input | 1 | Convergent rounding when 1 |
| cfg_sat_a | input | 1 | Saturation enable for A |
| cfg_sat_b | input | 1 | Saturation enable for B |
| cfg_sat39 | input | 1 | 1 = clamp at 40-bit range, 0 = clamp at 32-bit range |
| cfg_wsat | input | 1 | Clamp the stored word to 16-bit range |
| cfg_trap_en | input | 1 | Allow trap pulse on unsaturated overflow |
| clr_sat_a | input | 1 | Clear sticky saturation flag of A |
| clr_sat_b | input | 1 | Clear sticky saturation flag of B |
| st_req | input | 1 | Request a rounded store word |
| st_sel | input | 1 | Store source, 0 = A, 1 = B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov_a | output | 1 | A outside 32-bit range |
| ov_b | output | 1 | B outside 32-bit range |
| ov_any | output | 1 | OR of guard-overflow flags |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| sat_any | output | 1 | OR of sticky saturation flags |
| trap_req | output | 1 | One-cycle overflow trap pulse |
| st_valid | output | 1 | Store word valid |
| st_word | output | 16 | Rounded store word |

## Verification
The assertions assume that configuration inputs are stable during the cycle in which an operation issues and that `op_kind` values above 4 are only used as no-ops; the checks on range after 32-bit clamping rely on the target accumulator being written only through the operation port. The stimulus keeps within this by changing configuration only at the falling edge together with the operation it applies to, and it drives the 40-bit and 32-bit limits deliberately by repeatedly adding a near-2^33 product held in the other accumulator, then mixes this with a seeded random sequence of all operation codes, clears and stores.

// File: rtl/mac_sr_pkg.sv
package mac_sr_pkg;
  typedef enum logic [2:0] {
    OP_MAC_ADD = 3'd0,
    OP_MAC_SUB = 3'd1,
    OP_ACC_ADD = 3'd2,
    OP_ACC_SUB = 3'd3,
    OP_ACC_NEG = 3'd4
  } op_kind_e;

  function automatic logic op_is_legal(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic op_is_sub(logic [2:0] k);
    return (k == OP_MAC_SUB) || (k == OP_ACC_SUB) || (k == OP_ACC_NEG);
  endfunction
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int PW    = 2*DW + 2
) (
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic             zero_ext,
  input  logic             frac,
  output logic [ACC_W-1:0] prod_ext
);
  logic [DW:0]  wa, wb;
  logic [PW-1:0] xa, xb, raw, shifted;

  // widen operands to DW+1 bits, then to full product width
  assign wa = {opa[DW-1] & ~zero_ext, opa};
  assign wb = {opb[DW-1] & ~zero_ext, opb};
  assign xa = {{(PW-DW-1){wa[DW]}}, wa};
  assign xb = {{(PW-DW-1){wb[DW]}}, wb};
  assign raw = xa * xb;
  assign shifted = frac ? {raw[PW-2:0], 1'b0} : raw;
  assign prod_ext = {{(ACC_W-PW){shifted[PW-1]}}, shifted};
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int LOW_W = 2*DW
) (
  input  logic [ACC_W-1:0] base,
  input  logic [ACC_W-1:0] operand,
  input  logic             sub,
  input  logic             sat_en,
  input  logic             sat_full,
  output logic [ACC_W-1:0] result,
  output logic             ovf_full,
  output logic             sat_hit,
  output logic             guard_ov
);
  localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_LOW  = {{(GUARD+1){1'b0}}, {(LOW_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_LOW  = {{(GUARD+1){1'b1}}, {(LOW_W-1){1'b0}}};

  logic [ACC_W:0]     ext_base, ext_op, ext_neg, sum;
  logic [GUARD+1:0]   low_win;
  logic               ovf_low, neg;
  logic [GUARD:0]     res_win;

  assign ext_base = {base[ACC_W-1], base};
  assign ext_op   = {operand[ACC_W-1], operand};
  assign ext_neg  = -ext_op;
  assign sum      = ext_base + (sub ? ext_neg : ext_op);
  assign neg      = sum[ACC_W];
  assign ovf_full = sum[ACC_W] ^ sum[ACC_W-1];
  assign low_win  = sum[ACC_W:LOW_W-1];
  assign ovf_low  = !((&low_win) || !(|low_win));

  always_comb begin
    result  = sum[ACC_W-1:0];
    sat_hit = 1'b0;
    if (sat_en) begin
      if (sat_full) begin
        if (ovf_full) begin
          result  = neg ? MIN_FULL : MAX_FULL;
          sat_hit = 1'b1;
        end
      end else if (ovf_low) begin
        result  = neg ? MIN_LOW : MAX_LOW;
        sat_hit = 1'b1;
      end
    end else begin
      sat_hit = ovf_full;
    end
  end

  assign res_win  = result[ACC_W-1:LOW_W-1];
  assign guard_ov = !((&res_win) || !(|res_win));
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int HI_W  = ACC_W - DW
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             convergent,
  input  logic             clamp,
  output logic [DW-1:0]    word
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [HI_W:0] W_MAX = {{(HI_W-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [HI_W:0] W_MIN = {{(HI_W-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic              tie, inc;
  logic signed [HI_W:0] hi_rnd;

  assign tie    = (acc[DW-1:0] == HALF);
  assign inc    = (convergent && tie) ? acc[DW] : acc[DW-1];
  assign hi_rnd = $signed({acc[ACC_W-1], acc[ACC_W-1:DW]}) + $signed({{HI_W{1'b0}}, inc});

  always_comb begin
    word = hi_rnd[DW-1:0];
    if (clamp) begin
      if (hi_rnd > W_MAX)      word = {1'b0, {(DW-1){1'b1}}};
      else if (hi_rnd < W_MIN) word = {1'b1, {(DW-1){1'b0}}};
    end
  end
endmodule

// File: rtl/mac_satround.sv
module mac_satround
  import mac_sr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int N_ACC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic             acc_sel,
  input  logic [DW-1:0]    mul_a,
  input  logic [DW-1:0]    mul_b,
  input  logic             cfg_frac,
  input  logic             cfg_unsigned,
  input  logic             cfg_conv_rnd,
  input  logic             cfg_sat_a,
  input  logic             cfg_sat_b,
  input  logic             cfg_sat39,
  input  logic             cfg_wsat,
  input  logic             cfg_trap_en,
  input  logic             clr_sat_a,
  input  logic             clr_sat_b,
  input  logic             st_req,
  input  logic             st_sel,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ov_a,
  output logic             ov_b,
  output logic             ov_any,
  output logic             sat_a,
  output logic             sat_b,
  output logic             sat_any,
  output logic             trap_req,
  output logic             st_valid,
  output logic [DW-1:0]    st_word
);
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [N_ACC-1:0] ov_q, sat_q;
  logic [N_ACC-1:0] sat_en_v, clr_v, wr_v, hit_v, ovf_v, gov_v;
  logic [ACC_W-1:0] res_v [N_ACC];
  logic [ACC_W-1:0] prod;
  logic [DW-1:0]    rnd_word;
  logic             is_mac, is_neg, is_sub, legal;

  assign sat_en_v = {cfg_sat_b, cfg_sat_a};
  assign clr_v    = {clr_sat_b, clr_sat_a};
  assign legal    = op_is_legal(op_kind);
  assign is_mac   = (op_kind == OP_MAC_ADD) || (op_kind == OP_MAC_SUB);
  assign is_neg   = (op_kind == OP_ACC_NEG);
  assign is_sub   = op_is_sub(op_kind);

  mac_product #(.DW(DW), .GUARD(GUARD)) u_prod (
    .opa(mul_a), .opb(mul_b), .zero_ext(cfg_unsigned), .frac(cfg_frac),
    .prod_ext(prod)
  );

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] base, operand;
    assign base    = is_neg ? '0 : acc_q[g];
    assign operand = is_mac ? prod : (is_neg ? acc_q[g] : acc_q[N_ACC-1-g]);
    assign wr_v[g] = op_valid && legal && (acc_sel == g[0]);

    mac_addsat #(.DW(DW), .GUARD(GUARD)) u_sat (
      .base(base), .operand(operand), .sub(is_sub),
      .sat_en(sat_en_v[g]), .sat_full(cfg_sat39),
      .result(res_v[g]), .ovf_full(ovf_v[g]), .sat_hit(hit_v[g]),
      .guard_ov(gov_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[g] <= '0;
        ov_q[g]  <= 1'b0;
        sat_q[g] <= 1'b0;
      end else begin
        if (wr_v[g]) begin
          acc_q[g] <= res_v[g];
          ov_q[g]  <= gov_v[g];
        end
        // set has priority over clear
        sat_q[g] <= (sat_q[g] & ~clr_v[g]) | (wr_v[g] & hit_v[g]);
      end
    end
  end

  mac_round #(.DW(DW), .GUARD(GUARD)) u_rnd (
    .acc(st_sel ? acc_q[1] : acc_q[0]), .convergent(cfg_conv_rnd),
    .clamp(cfg_wsat), .word(rnd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      st_valid <= 1'b0;
      st_word  <= '0;
    end else begin
      trap_req <= cfg_trap_en && |(wr_v & ovf_v & ~sat_en_v);
      st_valid <= st_req;
      if (st_req) st_word <= rnd_word;
    end
  end

  assign acc_a   = acc_q[0];
  assign acc_b   = acc_q[1];
  assign ov_a    = ov_q[0];
  assign ov_b    = ov_q[1];
  assign sat_a   = sat_q[0];
  assign sat_b   = sat_q[1];
  assign ov_any  = |ov_q;
  assign sat_any = |sat_q;
endmodule

// File: rtl/mac_satround_chk.sv
module mac_satround_chk #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int LOW_W = 2*DW
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_kind,
  input logic             acc_sel,
  input logic             cfg_sat_a,
  input logic             cfg_sat39,
  input logic             cfg_trap_en,
  input logic             clr_sat_a,
  input logic             st_req,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic             ov_a,
  input logic             sat_a,
  input logic             trap_req,
  input logic             st_valid
);
  p_hold_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

  p_low_range_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind <= 3'd4 && !acc_sel && cfg_sat_a && !cfg_sat39)
    |=> (!ov_a && ((&acc_a[ACC_W-1:LOW_W-1]) || !(|acc_a[ACC_W-1:LOW_W-1]))));

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sat_a && !clr_sat_a) |=> sat_a);

  p_sticky_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_sat_a && !op_valid) |=> !sat_a);

  p_trap_cause_r6: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(op_valid && cfg_trap_en));

  p_store_timing_r12: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(st_req));
endmodule

bind mac_satround mac_satround_chk #(.DW(DW), .GUARD(GUARD)) u_chk (.*);

// File: tb/tb_mac_satround.sv
module tb_mac_satround;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        op_valid = 0, acc_sel = 0, st_req = 0, st_sel = 0;
  logic [2:0]  op_kind = 0;
  logic [15:0] mul_a = 0, mul_b = 0;
  logic cfg_frac = 0, cfg_unsigned = 0, cfg_conv_rnd = 0, cfg_sat_a = 0, cfg_sat_b = 0;
  logic cfg_sat39 = 0, cfg_wsat = 0, cfg_trap_en = 0, clr_sat_a = 0, clr_sat_b = 0;
  logic [39:0] acc_a, acc_b;
  logic ov_a, ov_b, ov_any, sat_a, sat_b, sat_any, trap_req, st_valid;
  logic [15:0] st_word;

  mac_satround dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint m_acc [2];
  bit m_ov [2], m_sat [2];
  bit m_trap, m_stv;
  logic [15:0] m_word;

  localparam longint MAX40 = 64'sh7F_FFFF_FFFF;
  localparam longint MIN40 = -64'sh80_0000_0000;
  localparam longint MAX32 = 64'sh7FFF_FFFF;
  localparam longint MIN32 = -64'sh8000_0000;

  function automatic longint f_prod(logic [15:0] a, logic [15:0] b, bit uns, bit frac);
    longint ea, eb, p;
    ea = uns ? longint'({48'd0, a}) : longint'({{48{a[15]}}, a});
    eb = uns ? longint'({48'd0, b}) : longint'({{48{b[15]}}, b});
    p = ea * eb;
    if (frac) p = p * 2;
    return p;
  endfunction

  function automatic logic [15:0] f_round(longint v, bit conv, bit clamp);
    longint hi, lo, r;
    bit inc;
    hi = v >>> 16;
    lo = v & 64'hFFFF;
    inc = (lo >= 64'h8000);
    if (conv && lo == 64'h8000) inc = hi[0];
    r = hi + longint'(inc);
    if (clamp && r > 32767) r = 32767;
    if (clamp && r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic bit f_gov(longint v);
    return (v > MAX32) || (v < MIN32);
  endfunction

  task automatic model_step();
    longint s, x, b, r;
    bit hit, sen, ovf;
    int t;
    m_stv = st_req;
    if (st_req) m_word = f_round(m_acc[st_sel], cfg_conv_rnd, cfg_wsat);
    m_trap = 0;
    for (int g = 0; g < 2; g++) if (clr_sat_a && g == 0 || clr_sat_b && g == 1) m_sat[g] = 0;
    if (op_valid && op_kind <= 4) begin
      t = int'(acc_sel);
      sen = (t == 0) ? cfg_sat_a : cfg_sat_b;
      b = (op_kind == 4) ? 0 : m_acc[t];
      case (op_kind)
        3'd0, 3'd1: x = f_prod(mul_a, mul_b, cfg_unsigned, cfg_frac);
        3'd4:       x = m_acc[t];
        default:    x = m_acc[1-t];
      endcase
      s = (op_kind == 1 || op_kind == 3 || op_kind == 4) ? b - x : b + x;
      ovf = (s > MAX40) || (s < MIN40);
      hit = 0;
      r = s;
      if (sen) begin
        if (cfg_sat39) begin
          if (ovf) begin r = (s > 0) ? MAX40 : MIN40; hit = 1; end
        end else if (s > MAX32) begin r = MAX32; hit = 1; end
        else if (s < MIN32) begin r = MIN32; hit = 1; end
      end else begin
        r = s & 64'hFF_FFFF_FFFF;
        if (r[39]) r = r - 64'sh100_0000_0000;
        hit = ovf;
        m_trap = ovf && cfg_trap_en;
      end
      m_acc[t] = r;
      m_ov[t] = f_gov(r);
      if (hit) m_sat[t] = 1;
    end
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "acc_a", longint'(acc_a), m_acc[0] & 64'hFF_FFFF_FFFF);
    chk(tag, "acc_b", longint'(acc_b), m_acc[1] & 64'hFF_FFFF_FFFF);
    chk(tag, "ov_a", longint'(ov_a), longint'(m_ov[0]));
    chk(tag, "ov_b", longint'(ov_b), longint'(m_ov[1]));
    chk(tag, "sat_a", longint'(sat_a), longint'(m_sat[0]));
    chk(tag, "sat_b", longint'(sat_b), longint'(m_sat[1]));
    chk("R7", "ov_any", longint'(ov_any), longint'(m_ov[0] | m_ov[1]));
    chk("R7", "sat_any", longint'(sat_any), longint'(m_sat[0] | m_sat[1]));
    chk(tag, "trap_req", longint'(trap_req), longint'(m_trap));
    chk(tag, "st_valid", longint'(st_valid), longint'(m_stv));
    if (m_stv) chk(tag, "st_word", longint'(st_word), longint'(m_word));
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    op_valid = 0; st_req = 0; clr_sat_a = 0; clr_sat_b = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    op_valid = 0; st_req = 0; clr_sat_a = 0; clr_sat_b = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int g = 0; g < 2; g++) begin m_acc[g] = 0; m_ov[g] = 0; m_sat[g] = 0; end
    m_trap = 0; m_stv = 0;
    compare("R13");
  endtask

  task automatic op(logic [2:0] k, logic sel, logic [15:0] a, logic [15:0] b, string tag);
    op_valid = 1; op_kind = k; acc_sel = sel; mul_a = a; mul_b = b;
    tick(tag);
  endtask

  task automatic store(logic sel, bit conv, bit ws, string tag);
    st_req = 1; st_sel = sel; cfg_conv_rnd = conv; cfg_wsat = ws;
    tick(tag);
  endtask

  task automatic load_big_b();
    cfg_unsigned = 1; cfg_frac = 1;
    op(3'd0, 1'b1, 16'hFFFF, 16'hFFFF, "R2");
    cfg_unsigned = 0; cfg_frac = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    do_reset();
    // R1 integer signed
    op(3'd0, 1'b0, 16'd3, -16'sd5, "R1");
    op(3'd0, 1'b0, 16'h8000, 16'h8000, "R1");
    // R2 fractional and unsigned
    do_reset();
    cfg_frac = 1;
    op(3'd0, 1'b0, 16'h4000, 16'h4000, "R2");
    cfg_frac = 0; cfg_unsigned = 1;
    op(3'd0, 1'b1, 16'hFFFF, 16'd2, "R2");
    cfg_unsigned = 0;
    // R3 other operations
    op(3'd3, 1'b0, 0, 0, "R3");
    op(3'd2, 1'b1, 0, 0, "R3");
    op(3'd4, 1'b1, 0, 0, "R3");
    op(3'd1, 1'b0, 16'd7, 16'd9, "R3");
    // R4 full-range clamp, R8 sticky and clear
    do_reset();
    load_big_b();
    cfg_sat_a = 1; cfg_sat39 = 1;
    for (int i = 0; i < 70; i++) op(3'd2, 1'b0, 0, 0, "R4");
    op(3'd3, 1'b1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) op(3'd0, 1'b1, 16'd1, 16'd1, "R8");
    clr_sat_a = 1; op_valid = 1; op_kind = 3'd2; acc_sel = 1'b0;
    tick("R8");
    clr_sat_a = 1;
    tick("R8");
    // R5 32-bit clamp
    do_reset();
    load_big_b();
    cfg_sat_a = 1; cfg_sat39 = 0;
    op(3'd2, 1'b0, 0, 0, "R5");
    op(3'd2, 1'b0, 0, 0, "R5");
    op(3'd4, 1'b0, 0, 0, "R5");
    op(3'd3, 1'b0, 0, 0, "R5");
    // R6 wrap and trap
    do_reset();
    load_big_b();
    cfg_sat_a = 0; cfg_trap_en = 1;
    for (int i = 0; i < 70; i++) op(3'd2, 1'b0, 0, 0, "R6");
    cfg_trap_en = 0;
    for (int i = 0; i < 70; i++) op(3'd3, 1'b0, 0, 0, "R6");
    // R9 and R10 rounding
    do_reset();
    op(3'd0, 1'b0, 16'd16384, 16'd2, "R9");
    store(1'b0, 0, 0, "R9");
    store(1'b0, 1, 0, "R10");
    op(3'd0, 1'b0, 16'd16384, 16'd4, "R10");
    store(1'b0, 1, 0, "R10");
    store(1'b0, 0, 0, "R9");
    op(3'd1, 1'b0, 16'd1, 16'd1, "R9");
    store(1'b0, 1, 0, "R9");
    // R11 write clamp
    do_reset();
    cfg_unsigned = 1; cfg_frac = 1;
    op(3'd0, 1'b1, 16'hFFFF, 16'hFFFF, "R11");
    cfg_unsigned = 0; cfg_frac = 0;
    store(1'b1, 0, 1, "R11");
    store(1'b1, 0, 0, "R11");
    op(3'd4, 1'b1, 0, 0, "R11");
    store(1'b1, 1, 1, "R11");
    // R12 store with concurrent op reads old value
    st_req = 1; st_sel = 1; op_valid = 1; op_kind = 3'd0; acc_sel = 1; mul_a = 16'd300; mul_b = 16'd300;
    tick("R12");
    store(1'b1, 0, 0, "R12");
    // R13 ignored operations
    op_valid = 0; op_kind = 3'd0; mul_a = 16'd5; mul_b = 16'd5;
    tick("R13");
    op(3'd6, 1'b0, 16'd5, 16'd5, "R13");
    op(3'd7, 1'b1, 16'd5, 16'd5, "R13");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      op_valid = ($urandom % 5) != 0;
      op_kind = 3'($urandom % 6);
      acc_sel = 1'($urandom); mul_a = 16'($urandom); mul_b = 16'($urandom);
      cfg_frac = 1'($urandom); cfg_unsigned = 1'($urandom); cfg_conv_rnd = 1'($urandom);
      cfg_sat_a = ($urandom % 4) != 0; cfg_sat_b = ($urandom % 4) != 0;
      cfg_sat39 = 1'($urandom); cfg_wsat = 1'($urandom); cfg_trap_en = 1'($urandom);
      clr_sat_a = ($urandom % 16) == 0; clr_sat_b = ($urandom % 16) == 0;
      st_req = ($urandom % 3) == 0; st_sel = 1'($urandom);
      tick((op_kind <= 1) ? "R1" : "R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule